// File: doc/BRIEF.md
# Three-Level Trigger Sequence Controller

This controller tracks one readout node through a three-stage trigger handshake. A first-level pulse opens a timed wait for a second-level decision, and a second-level pulse opens a timed wait for a final accept or reject. Every wait starts with a blocking stretch and then moves into an accepting stretch. Each stretch has a length in clock cycles that is set through input ports. The pulses arrive already decoded, one cycle each, from a link decoder that sits upstream.

A pulse that repeats inside a wait that is already running does not raise an error. It restarts the count of the wait it belongs to. An event closes in one of four ways: a final accept, a final reject, a final-stage timeout, or a start-of-data or end-of-data marker. Each closing state holds until the end-of-event indication arrives. If the second-level pulse never comes, the node requests a flush for one cycle and goes back to rest.

The encoded state and four single-cycle-accurate flags are the only outputs.

Top module: `trig_seq_ctrl`

## Requirements
- R1: While reset is low the controller sits in REST and all four flags are low. The state codes are REST=0, T1_HOLD=1, T1_OPEN=2, T2_HOLD=3, T2_OPEN=4, ACCEPTED=5, REJECTED=6, EXPIRED=7, MARKER=8, FLUSHING=9. The window timer is cleared, so the first wait after reset lasts its full length.
- R2: In REST, a first-level pulse moves the controller to T1_HOLD. T1_HOLD lasts `t1_hold_len` cycles, with a minimum of 1, and then moves to T1_OPEN.
- R3: A first-level pulse in T1_HOLD or T1_OPEN restarts the first wait. The controller re-enters T1_HOLD with a fresh full-length count.
- R4: A second-level pulse in T1_OPEN moves the controller to T2_HOLD. T2_HOLD lasts `t2_hold_len` cycles, with a minimum of 1, and then moves to T2_OPEN. A second-level pulse in T1_HOLD is ignored.
- R5: A second-level pulse in T2_HOLD or T2_OPEN restarts the second wait. The controller re-enters T2_HOLD with a fresh full-length count.
- R6: In T2_OPEN, a final accept moves the controller to ACCEPTED and a final reject moves it to REJECTED. If both arrive together, accept wins. Final decisions in any other state are ignored.
- R7: If T2_OPEN sees no final decision for `t2_open_len` cycles, the controller moves to EXPIRED.
- R8: If T1_OPEN sees no second-level pulse for `t1_open_len` cycles, the controller spends exactly one cycle in FLUSHING and then returns to REST.
- R9: In REST, a data marker with no first-level pulse moves the controller to MARKER. A first-level pulse takes priority over a marker in the same cycle.
- R10: ACCEPTED, REJECTED, EXPIRED and MARKER hold, ignoring trigger pulses, until end-of-event returns the controller to REST. End-of-event in any other state has no effect.
- R11: `accept_o`, `reject_o`, `timeout_o` and `flush_o` are high exactly while the state is ACCEPTED, REJECTED, EXPIRED and FLUSHING respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_pulse | input | 1 | Decoded first-level trigger |
| t1_pulse | input | 1 | Decoded second-level trigger |
| t2_acc_pulse | input | 1 | Decoded final accept |
| t2_rej_pulse | input | 1 | Decoded final reject |
| data_mark | input | 1 | Start-of-data or end-of-data marker |
| end_evt | input | 1 | End-of-event indication |
| t1_hold_len | input | CNT_W | Cycles in the first blocking stretch |
| t1_open_len | input | CNT_W | Cycles in the first accepting stretch |
| t2_hold_len | input | CNT_W | Cycles in the second blocking stretch |
| t2_open_len | input | CNT_W | Cycles in the second accepting stretch |
| state_o | output | 4 | Encoded controller state |
| accept_o | output | 1 | Final accept outcome |
| reject_o | output | 1 | Final reject outcome |
| timeout_o | output | 1 | Final-stage timeout outcome |
| flush_o | output | 1 | Flush request |

## Verification
The bench times every blocking and accepting stretch to the exact cycle. A timer that is off by one, or that does not clear on entry, shows up as an early or late state change.

Repeated pulses are sent in the middle of a wait. A design that ignored them, or that treated them as fresh events without clearing the count, would leave the wait too early.

The bench also sends decisions and end-of-event in the wrong states, sends accept and reject in the same cycle, and sends a marker together with a first-level pulse. These catch a controller that leaks out of a closing state, picks the wrong priority, or drops the one-cycle flush.

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t0_pulse,
  input  logic             t1_pulse,
  input  logic             t2_acc_pulse,
  input  logic             t2_rej_pulse,
  input  logic             data_mark,
  input  logic             end_evt,
  input  logic [CNT_W-1:0] t1_hold_len,
  input  logic [CNT_W-1:0] t1_open_len,
  input  logic [CNT_W-1:0] t2_hold_len,
  input  logic [CNT_W-1:0] t2_open_len,
  output logic [3:0]       state_o,
  output logic             accept_o,
  output logic             reject_o,
  output logic             timeout_o,
  output logic             flush_o
);

  typedef enum logic [3:0] {
    REST     = 4'd0,
    T1_HOLD  = 4'd1,
    T1_OPEN  = 4'd2,
    T2_HOLD  = 4'd3,
    T2_OPEN  = 4'd4,
    ACCEPTED = 4'd5,
    REJECTED = 4'd6,
    EXPIRED  = 4'd7,
    MARKER   = 4'd8,
    FLUSHING = 4'd9
  } st_t;

  st_t             st_q, st_d;
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] cur_len;
  logic             restart;
  logic             expire;

  always_comb begin
    case (st_q)
      T1_HOLD: cur_len = t1_hold_len;
      T1_OPEN: cur_len = t1_open_len;
      T2_HOLD: cur_len = t2_hold_len;
      T2_OPEN: cur_len = t2_open_len;
      default: cur_len = '0;
    endcase
  end

  assign expire = ({1'b0, tmr_q} + 1'b1) >= {1'b0, cur_len};

  always_comb begin
    st_d    = st_q;
    restart = 1'b0;
    case (st_q)
      REST: begin
        if (t0_pulse) begin
          st_d = T1_HOLD; restart = 1'b1;
        end else if (data_mark) begin
          st_d = MARKER;
        end
      end
      T1_HOLD: begin
        if (t0_pulse) restart = 1'b1;
        else if (expire) begin
          st_d = T1_OPEN; restart = 1'b1;
        end
      end
      T1_OPEN: begin
        if (t0_pulse) begin
          st_d = T1_HOLD; restart = 1'b1;
        end else if (t1_pulse) begin
          st_d = T2_HOLD; restart = 1'b1;
        end else if (expire) begin
          st_d = FLUSHING; restart = 1'b1;
        end
      end
      T2_HOLD: begin
        if (t1_pulse) restart = 1'b1;
        else if (expire) begin
          st_d = T2_OPEN; restart = 1'b1;
        end
      end
      T2_OPEN: begin
        if (t2_acc_pulse) begin
          st_d = ACCEPTED; restart = 1'b1;
        end else if (t2_rej_pulse) begin
          st_d = REJECTED; restart = 1'b1;
        end else if (t1_pulse) begin
          st_d = T2_HOLD; restart = 1'b1;
        end else if (expire) begin
          st_d = EXPIRED; restart = 1'b1;
        end
      end
      ACCEPTED, REJECTED, EXPIRED, MARKER: begin
        if (end_evt) st_d = REST;
      end
      FLUSHING: st_d = REST;
      default:  st_d = REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= REST;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= restart ? '0 : tmr_q + 1'b1;
    end
  end

  assign state_o   = st_q;
  assign accept_o  = (st_q == ACCEPTED);
  assign reject_o  = (st_q == REJECTED);
  assign timeout_o = (st_q == EXPIRED);
  assign flush_o   = (st_q == FLUSHING);

  p_reset_rest_r1: assert property (@(posedge clk)
    !rst_n |-> (st_q == REST && tmr_q == '0));

  p_t0_from_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == REST && t0_pulse) |=> (st_q == T1_HOLD && tmr_q == '0));

  p_t0_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == T1_HOLD || st_q == T1_OPEN) && t0_pulse) |=> (st_q == T1_HOLD && tmr_q == '0));

  p_t1_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T2_HOLD && t1_pulse) |=> (st_q == T2_HOLD && tmr_q == '0));

  p_accept_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T2_OPEN && t2_acc_pulse) |=> accept_o);

  p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (!flush_o && state_o == REST));

  p_closing_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept_o || reject_o || timeout_o || st_q == MARKER) && !end_evt) |=> $stable(state_o));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_o, reject_o, timeout_o, flush_o}));

endmodule

// File: tb/tb_trig_seq_ctrl.sv
module tb_trig_seq_ctrl;
  localparam int CNT_W = 16;
  localparam int H1 = 3, O1 = 5, H2 = 2, O2 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t0 = 0, t1 = 0, ta = 0, tr = 0, dm = 0, ee = 0;
  logic [3:0] state_o;
  logic accept_o, reject_o, timeout_o, flush_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  trig_seq_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .t0_pulse(t0), .t1_pulse(t1), .t2_acc_pulse(ta), .t2_rej_pulse(tr),
    .data_mark(dm), .end_evt(ee),
    .t1_hold_len(CNT_W'(H1)), .t1_open_len(CNT_W'(O1)),
    .t2_hold_len(CNT_W'(H2)), .t2_open_len(CNT_W'(O2)),
    .state_o(state_o), .accept_o(accept_o), .reject_o(reject_o),
    .timeout_o(timeout_o), .flush_o(flush_o)
  );

  function automatic logic [7:0] pack_exp(input int s);
    return {4'(s), s == 5, s == 6, s == 7, s == 9};
  endfunction

  task automatic compare(input int s, input string tag);
    logic [7:0] act, exp;
    act = {state_o, accept_o, reject_o, timeout_o, flush_o};
    exp = pack_exp(s);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual state/flags %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic step(input logic a0, a1, a2a, a2r, m, e, input int s, input string tag);
    @(negedge clk);
    t0 = a0; t1 = a1; ta = a2a; tr = a2r; dm = m; ee = e;
    exp_q.push_back(s);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input int s, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, s, tag);
  endtask

  task automatic to_t2_open(input string tag);
    step(1, 0, 0, 0, 0, 0, 1, tag);
    idle(H1 - 1, 1, tag);
    idle(1, 2, tag);
    step(0, 1, 0, 0, 0, 0, 3, tag);
    idle(H2 - 1, 3, tag);
    idle(1, 4, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 0, "R1 rest after reset");

    to_t2_open("R2 R4 timed waits");
    step(0, 0, 1, 0, 0, 0, 5, "R6 accept");
    idle(2, 5, "R10 R11 accept holds");
    step(0, 0, 0, 0, 0, 1, 0, "R10 end-of-event");

    to_t2_open("R4 path to reject");
    step(0, 0, 0, 1, 0, 0, 6, "R6 reject");
    step(1, 1, 0, 0, 0, 0, 6, "R10 triggers ignored in reject");
    step(0, 0, 0, 0, 0, 1, 0, "R10 end-of-event");

    to_t2_open("R7 path");
    idle(O2 - 1, 4, "R7 open window");
    idle(1, 7, "R7 timeout");
    step(0, 0, 0, 0, 0, 1, 0, "R10 exit timeout");

    step(1, 0, 0, 0, 0, 0, 1, "R8 path");
    idle(H1 - 1, 1, "R8 hold");
    idle(O1, 2, "R8 open window");
    idle(1, 9, "R8 flush");
    idle(1, 0, "R8 back to rest");

    step(1, 0, 0, 0, 0, 0, 1, "R3 start");
    idle(1, 1, "R3 hold");
    step(1, 0, 0, 0, 0, 0, 1, "R3 restart in hold");
    step(0, 1, 0, 0, 0, 0, 1, "R4 t1 ignored in hold");
    idle(H1 - 2, 1, "R3 fresh count");
    idle(1, 2, "R3 reach open");
    step(1, 0, 0, 0, 0, 0, 1, "R3 restart from open");
    idle(H1 - 1, 1, "R3 hold again");
    idle(1, 2, "R3 open again");
    step(0, 1, 0, 0, 0, 0, 3, "R4 to t2 hold");
    step(0, 0, 1, 0, 0, 0, 3, "R6 accept ignored in hold");
    step(0, 1, 0, 0, 0, 0, 3, "R5 restart in t2 hold");
    idle(H2 - 1, 3, "R5 fresh count");
    idle(1, 4, "R5 reach open");
    step(0, 1, 0, 0, 0, 0, 3, "R5 restart from t2 open");
    idle(H2 - 1, 3, "R5 hold again");
    idle(1, 4, "R5 open again");
    step(0, 0, 1, 1, 0, 0, 5, "R6 accept wins tie");
    step(0, 0, 0, 0, 0, 1, 0, "R10 exit");

    step(0, 0, 1, 1, 0, 1, 0, "R6 R10 ignored in rest");
    step(1, 0, 0, 0, 1, 0, 1, "R9 t0 beats marker");
    step(0, 0, 0, 0, 0, 0, 1, "R9 in hold");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    compare(0, "R1 reset mid event");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 1, 0, 8, "R9 marker");
    step(1, 0, 0, 0, 0, 0, 8, "R9 trigger ignored in marker");
    step(0, 0, 0, 0, 0, 1, 0, "R10 marker exit");
    idle(2, 0, "R1 quiet");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule